// File: doc/BRIEF.md
# Boot-Time Code Protection and Test-Mode Gate

This block sits beside a processor core and decides, before the core runs any instruction, whether the on-chip program is protected. Out of reset it reads one protection word from a fixed program-memory address over a request/valid handshake and stores it. It then reports the code as secured or open, and keeps the core stalled until that stored word exists.

The same gate controls entry to the three test modes: memory programming, emulation and trace. Entering any test mode reruns the protection-word load, so protection is always in force inside a test mode. Moving straight between emulation and trace is not possible; such a move must pass through a fresh load. The one exception is a fall of the programming-voltage level while in trace mode, which moves the block to emulation without a new load and leaves the protection state as it was. While emulation is active, the core's table reads and long-constant fetches are routed to the external program source.

Top module: `bsec_gate`

## Requirements
- R1: While reset is asserted and directly after it, core_stall=1, mem_req=1, mem_addr equals the parameter PW_ADDR, cur_mode=0 (NORMAL) and secured=1.
- R2: core_stall and mem_req stay 1 until a clock edge samples mem_valid=1. From the next cycle both are 0 and the stored word is the mem_data of that edge. mem_data on cycles without mem_valid is never stored.
- R3: secured is 0 only when a load has completed and the stored word equals the parameter OPEN_KEY. Any other stored word gives 1, and secured is 1 while a load is running.
- R4: Modes are encoded NORMAL=0, PROGRAM=1, EMULATE=2, TRACE=3. A request (mode_req_valid=1) for a test mode other than the current one starts a load: from the next cycle core_stall=1, mem_req=1, secured=1 and cur_mode=0. When the load completes, the requested mode is applied, so emulation and trace never follow each other directly through a request.
- R5: A request made while a load is running is held; the latest one wins and is applied in the cycle after the load completes.
- R6: In TRACE, a 1-to-0 change of vpp_high between two clock edges switches cur_mode to 2 one cycle later, with no load, no stall and no change to secured.
- R7: A request for NORMAL takes effect the next cycle with no load. A request for the mode already active changes nothing.
- R8: ext_sel=tbl_access when cur_mode=2, otherwise int_sel=tbl_access. Both are combinational in the same cycle.
- R9: Reset during a load discards any held request; the load after reset ends in NORMAL.
- R10: A vpp_high fall outside TRACE changes nothing. In TRACE, a request that arrives in the same cycle as the fall takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Protection-word read request |
| mem_addr | output | AW | Protection-word address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | DW | Read data |
| mode_req_valid | input | 1 | Mode request strobe |
| mode_req | input | 2 | Requested mode |
| vpp_high | input | 1 | Programming-voltage level |
| tbl_access | input | 1 | Core table or long-constant access |
| core_stall | output | 1 | Holds the core |
| cur_mode | output | 2 | Active mode |
| secured | output | 1 | Code protected |
| ext_sel | output | 1 | Route access to the external source |
| int_sel | output | 1 | Route access to internal memory |

## Verification
Every registered result (stall, request, mode, secure flag) is due exactly one clock after the edge that samples its cause. A request or voltage fall is sampled at one edge and takes effect on the following one. The routing selects follow tbl_access in the same cycle. The bench drives inputs on the falling edge, updates a behavioural model on the rising edge and compares all outputs 3 ns later, so every result is checked in the cycle it is due. Explicit scenario checks sample at that same point.

// File: rtl/bsec_pkg.sv
package bsec_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_PROG   = 2'd1,
    MODE_EMUL   = 2'd2,
    MODE_TRACE  = 2'd3
  } tmode_e;
endpackage

// File: rtl/bsec_loader.sv
module bsec_loader #(
  parameter int            DW       = 16,
  parameter logic [DW-1:0] OPEN_KEY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_chk,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_data,
  output logic          busy,
  output logic          done,
  output logic          secured
);
  logic          busy_q, busy_d;
  logic          vld_q, vld_d;
  logic          word_en;
  logic [DW-1:0] word_q;

  always_comb begin
    done    = busy_q && mem_valid;
    word_en = done;
    busy_d  = busy_q;
    vld_d   = vld_q;
    if (busy_q) begin
      if (mem_valid) begin
        busy_d = 1'b0;
        vld_d  = 1'b1;
      end
    end else if (start_chk) begin
      busy_d = 1'b1;
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      vld_q  <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= mem_data;
  end

  assign busy    = busy_q;
  assign secured = !(vld_q && (word_q == OPEN_KEY));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_valid |=> busy);
  // R2
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_valid |=> !busy);
  // R3
  secure_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> secured);
  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_chk |=> busy && secured);
endmodule

// File: rtl/bsec_arb.sv
module bsec_arb
  import bsec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       vpp_high,
  input  logic       chk_busy,
  input  logic       chk_done,
  output logic       start_chk,
  output tmode_e     mode
);
  tmode_e mode_q, mode_d, pend_q, pend_d, req_m;
  logic   pend_vld_q, pend_vld_d;
  logic   vpp_q, vpp_fall;

  always_comb begin
    req_m      = tmode_e'(req_mode);
    vpp_fall   = vpp_q && !vpp_high;
    mode_d     = mode_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    start_chk  = 1'b0;
    if (chk_busy) begin
      if (req_valid) begin
        pend_d     = req_m;
        pend_vld_d = 1'b1;
      end
      if (chk_done) begin
        mode_d     = pend_vld_d ? pend_d : MODE_NORMAL;
        pend_vld_d = 1'b0;
      end
    end else if (req_valid && req_m != mode_q && req_m != MODE_NORMAL) begin
      start_chk  = 1'b1;
      pend_d     = req_m;
      pend_vld_d = 1'b1;
      mode_d     = MODE_NORMAL;
    end else if (req_valid && req_m == MODE_NORMAL) begin
      mode_d = MODE_NORMAL;
    end else if (mode_q == MODE_TRACE && vpp_fall) begin
      mode_d = MODE_EMUL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_NORMAL;
      pend_q     <= MODE_NORMAL;
      pend_vld_q <= 1'b0;
      vpp_q      <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
      vpp_q      <= vpp_high;
    end
  end

  assign mode = mode_q;

  // R4
  busy_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_busy |-> mode_q == MODE_NORMAL);
  // R4
  trace_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TRACE && $past(mode_q) != MODE_TRACE) |-> $past(chk_done));
  // R4
  prog_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PROG && $past(mode_q) != MODE_PROG) |-> $past(chk_done));
  // R6
  emul_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_EMUL && $past(mode_q) != MODE_EMUL)
      |-> ($past(chk_done) || $past(mode_q) == MODE_TRACE));
endmodule

// File: rtl/bsec_gate.sv
module bsec_gate
  import bsec_pkg::*;
#(
  parameter int            AW       = 12,
  parameter int            DW       = 16,
  parameter logic [AW-1:0] PW_ADDR  = 12'hFFE,
  parameter logic [DW-1:0] OPEN_KEY = 16'h5A3C
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_data,
  input  logic          mode_req_valid,
  input  logic [1:0]    mode_req,
  input  logic          vpp_high,
  input  logic          tbl_access,
  output logic          core_stall,
  output logic [1:0]    cur_mode,
  output logic          secured,
  output logic          ext_sel,
  output logic          int_sel
);
  logic   chk_busy, chk_done, start_chk, emul_on;
  tmode_e mode;

  bsec_loader #(.DW(DW), .OPEN_KEY(OPEN_KEY)) u_load (
    .clk(clk), .rst_n(rst_n), .start_chk(start_chk), .mem_valid(mem_valid),
    .mem_data(mem_data), .busy(chk_busy), .done(chk_done), .secured(secured)
  );

  bsec_arb u_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(mode_req_valid), .req_mode(mode_req),
    .vpp_high(vpp_high), .chk_busy(chk_busy), .chk_done(chk_done),
    .start_chk(start_chk), .mode(mode)
  );

  assign emul_on    = (mode == MODE_EMUL);
  assign mem_req    = chk_busy;
  assign mem_addr   = PW_ADDR;
  assign core_stall = chk_busy;
  assign cur_mode   = mode;
  assign ext_sel    = tbl_access && emul_on;
  assign int_sel    = tbl_access && !emul_on;
endmodule

// File: tb/sim_bsec_gate.sv
`timescale 1ns/1ps
module sim_bsec_gate;
  localparam logic [11:0] ADDR = 12'hFFE;
  localparam logic [15:0] KEY  = 16'h5A3C;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, mem_req, mem_valid, rq_v, vpp, tbl;
  logic        core_stall, secured, ext_sel, int_sel;
  logic [11:0] mem_addr;
  logic [15:0] mem_data;
  logic [1:0]  rq, cur_mode;

  bsec_gate u0 (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data), .mode_req_valid(rq_v),
    .mode_req(rq), .vpp_high(vpp), .tbl_access(tbl), .core_stall(core_stall),
    .cur_mode(cur_mode), .secured(secured), .ext_sel(ext_sel), .int_sel(int_sel)
  );

  int tests = 0, fails = 0;
  int mem_lat = 2;
  logic [15:0] mem_word = KEY;
  int cnt = 0;

  // behavioural reference state
  bit m_busy = 1, m_vld = 0, m_vpp = 0;
  int m_mode = 0, m_pend = -1;
  logic [15:0] m_word = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    if (!mem_req) begin
      cnt = 0; mem_valid = 1'b0; mem_data = 16'hDEAD;
    end else begin
      if (cnt >= mem_lat) begin mem_valid = 1'b1; mem_data = mem_word; end
      else begin mem_valid = 1'b0; mem_data = 16'hDEAD; end
      cnt++;
    end
  end

  // reference model update and per-cycle comparison
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1; m_vld = 0; m_mode = 0; m_pend = -1; m_vpp = 0;
    end else begin
      if (m_busy) begin
        if (rq_v) m_pend = int'(rq);
        if (mem_valid) begin
          m_word = mem_data; m_vld = 1; m_busy = 0;
          m_mode = (m_pend >= 0) ? m_pend : 0; m_pend = -1;
        end
      end else if (rq_v && int'(rq) != m_mode && rq != 2'd0) begin
        m_busy = 1; m_vld = 0; m_pend = int'(rq); m_mode = 0;
      end else if (rq_v && rq == 2'd0) begin
        m_mode = 0;
      end else if (m_mode == 3 && m_vpp && !vpp) begin
        m_mode = 2;
      end
      m_vpp = vpp;
    end
    #3;
    chk(core_stall == m_busy, "R2", "core_stall", core_stall, m_busy);
    chk(mem_req == m_busy, "R2", "mem_req", mem_req, m_busy);
    chk(secured == !(m_vld && m_word == KEY), "R3", "secured", secured,
        !(m_vld && m_word == KEY));
    chk(int'(cur_mode) == m_mode, "R4", "cur_mode", cur_mode, m_mode);
    chk(ext_sel == (tbl && m_mode == 2), "R8", "ext_sel", ext_sel, tbl && m_mode == 2);
    chk(int_sel == (tbl && m_mode != 2), "R8", "int_sel", int_sel, tbl && m_mode != 2);
  end

  task automatic pulse_req(input logic [1:0] m);
    @(negedge clk); rq_v = 1'b1; rq = m;
    @(posedge clk); #3;
  endtask

  task automatic end_req();
    @(negedge clk); rq_v = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 60; i++) begin
      if (!core_stall) break;
      @(posedge clk); #3;
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: act=hang exp=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rq_v = 1'b0; rq = 2'd0; vpp = 1'b0; tbl = 1'b0;
    mem_valid = 1'b0; mem_data = 16'hDEAD;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(core_stall == 1'b1, "R1", "stall in reset", core_stall, 1);
    chk(mem_req == 1'b1, "R1", "mem_req in reset", mem_req, 1);
    chk(mem_addr == ADDR, "R1", "mem_addr", mem_addr, ADDR);
    chk(cur_mode == 2'd0, "R1", "mode in reset", cur_mode, 0);
    chk(secured == 1'b1, "R1", "secured in reset", secured, 1);
    rst_n = 1'b1; vpp = 1'b1;
    wait_ready();
    chk(secured == 1'b0, "R3", "open key clears secured", secured, 0);

    // R4: enter programming, then trace, then emulation via a load
    pulse_req(2'd1);
    chk(core_stall && cur_mode == 2'd0, "R4", "load starts", core_stall, 1);
    end_req(); wait_ready();
    chk(cur_mode == 2'd1, "R4", "program granted", cur_mode, 1);
    pulse_req(2'd3); end_req(); wait_ready();
    chk(cur_mode == 2'd3, "R4", "trace granted", cur_mode, 3);
    pulse_req(2'd2);
    chk(core_stall == 1'b1, "R4", "trace->emul needs load", core_stall, 1);
    end_req(); wait_ready();
    chk(cur_mode == 2'd2, "R4", "emul granted", cur_mode, 2);

    // R6: voltage fall from trace
    pulse_req(2'd3); end_req(); wait_ready();
    @(negedge clk); vpp = 1'b0;
    @(posedge clk); #3;
    chk(cur_mode == 2'd2 && !core_stall, "R6", "vpp fall to emul", cur_mode, 2);
    chk(secured == 1'b0, "R6", "secured kept", secured, 0);

    // R8 routing
    @(negedge clk); tbl = 1'b1; #1;
    chk(ext_sel == 1'b1 && int_sel == 1'b0, "R8", "ext in emul", ext_sel, 1);

    // R7 request NORMAL directly, then same-mode request ignored
    pulse_req(2'd0);
    chk(cur_mode == 2'd0 && !core_stall, "R7", "normal direct", cur_mode, 0);
    chk(int_sel == 1'b1 && ext_sel == 1'b0, "R8", "int in normal", int_sel, 1);
    end_req();
    pulse_req(2'd0);
    chk(cur_mode == 2'd0 && !core_stall, "R7", "same mode ignored", cur_mode, 0);
    end_req(); tbl = 1'b0;

    // R10 voltage fall outside trace
    @(negedge clk); vpp = 1'b1;
    @(negedge clk); vpp = 1'b0;
    @(posedge clk); #3;
    chk(cur_mode == 2'd0, "R10", "vpp fall in normal", cur_mode, 0);

    // R5 held request, latest wins; R3 secured with other word
    mem_lat = 6; mem_word = 16'h1234;
    pulse_req(2'd1); end_req();
    pulse_req(2'd3); end_req();
    wait_ready();
    chk(cur_mode == 2'd3, "R5", "latest held request", cur_mode, 3);
    chk(secured == 1'b1, "R3", "other word secured", secured, 1);

    // R10 request beats voltage fall in trace
    @(negedge clk); vpp = 1'b1;
    @(negedge clk); vpp = 1'b0; rq_v = 1'b1; rq = 2'd0;
    @(posedge clk); #3;
    chk(cur_mode == 2'd0, "R10", "request over vpp fall", cur_mode, 0);
    end_req();

    // R9 reset during load drops held request
    mem_lat = 2; mem_word = KEY;
    pulse_req(2'd1); end_req();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wait_ready();
    chk(cur_mode == 2'd0, "R9", "reset drops request", cur_mode, 0);
    chk(secured == 1'b0, "R9", "reload after reset", secured, 0);

    repeat (4) @(posedge clk);
    #3;
    finish_run();
  end
endmodule